// File: doc/BRIEF.md
# OFDM Subcarrier Data and Pilot Assembler

This block builds one frequency-domain OFDM symbol of 256 bins for a following inverse FFT. Two producers feed it, each with its own valid/ready handshake and its own timing. One supplies modulated data symbols and the other supplies pilot symbols. The block writes every accepted symbol straight into its bin of a 256-entry symbol store, so the two streams never have to arrive together.

The occupied band has 180 bins in the middle of the spectrum. It is built from 30 groups, and each group is one pilot bin followed by five data bins. There are 38 empty guard bins below the band and 38 above it. When all 30 pilots and all 150 data symbols are in, the block stops accepting input. It then plays out the whole symbol in bin order for 256 cycles in a row, giving zero on every guard bin. After the last word it starts filling the next symbol.

Top module: `subcarrier_assembler`

## Requirements
- R1: After reset, out_valid is 0 and both pilot_ready and data_ready are 1.
- R2: The k-th pilot accepted in a symbol (k counted from 0) appears in the output at bin 38+6k.
- R3: The j-th data word accepted in a symbol (j counted from 0) appears in the output at bin 38 + 6*floor(j/5) + 1 + (j mod 5).
- R4: Bins 0..37 and 218..255 are output as all-zero words in every symbol, not only the first one after reset.
- R5: Once 30 pilots are accepted, pilot_ready stays 0 until the readout ends, and an offered pilot is ignored. Likewise, once 150 data words are accepted, data_ready stays 0 until the readout ends.
- R6: In a cycle where a pilot is offered and pilot_ready is 1, data_ready is 0, so the pilot is taken first.
- R7: out_valid is never 1 before all 30 pilots and all 150 data words of the symbol have been accepted.
- R8: The readout is 256 words on 256 consecutive cycles, in rising bin order. out_last is 1 only on the word for bin 255.
- R9: While the readout runs, before the cycle that carries out_last, both pilot_ready and data_ready are 0.
- R10: A word is 22 bits: I as 11-bit two's complement in bits 21:11 and Q in bits 10:0. Every occupied bin is output bit-exact as it was accepted.
- R11: After a readout, the next symbol is accepted with its pilot and data counts restarted at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pilot_valid | input | 1 | Pilot word offered |
| pilot_ready | output | 1 | Pilot word can be accepted this cycle |
| pilot_data | input | 22 | Pilot I/Q word |
| data_valid | input | 1 | Data word offered |
| data_ready | output | 1 | Data word can be accepted this cycle |
| data_data | input | 22 | Data I/Q word |
| out_valid | output | 1 | Output bin word valid |
| out_last | output | 1 | Marks the word for bin 255 |
| out_data | output | 22 | Output bin I/Q word |

## Verification
The bench runs symbols under several arrival orders: random gaps on both inputs, all pilots first, all data first, and both inputs valid on every cycle. In each order it checks every one of the 256 output bins against a bin map computed on its own. A design that slips the data group stride, or that forgets the pilot slot, puts words one bin off or overwrites pilots, and both show up as mismatches. A design that breaks the pilot priority rule when both inputs are valid puts two words on one write port, so one of them is lost. Extra words offered after a stream is full must not overwrite anything. The bench watches for a readout that starts early, a last marker on the wrong word, and guard bins that are not zero on symbols after the first.

// File: rtl/sc_asm_pkg.sv
package sc_asm_pkg;

    localparam int FFT_N_DEF  = 256;
    localparam int GUARD_DEF  = 38;
    localparam int PILOTS_DEF = 30;
    localparam int GROUP_DEF  = 5;
    localparam int IQ_W_DEF   = 11;

    typedef struct packed {
        logic signed [IQ_W_DEF-1:0] i;
        logic signed [IQ_W_DEF-1:0] q;
    } iq_t;

    typedef enum logic {
        PH_FILL  = 1'b0,
        PH_DRAIN = 1'b1
    } phase_t;

    // True when bin index lies outside [lo, hi)
    function automatic logic outside_band(input int idx, input int lo, input int hi);
        return (idx < lo) || (idx >= hi);
    endfunction

endpackage

// File: rtl/asm_addr_gen.sv
module asm_addr_gen #(
    parameter int FFT_N  = sc_asm_pkg::FFT_N_DEF,
    parameter int GUARD  = sc_asm_pkg::GUARD_DEF,
    parameter int PILOTS = sc_asm_pkg::PILOTS_DEF,
    parameter int GROUP  = sc_asm_pkg::GROUP_DEF,
    localparam int ADDR_W = $clog2(FFT_N),
    localparam int DATA_N = PILOTS * GROUP,
    localparam int CNT_W  = $clog2(DATA_N + 1),
    localparam int SUB_W  = (GROUP > 1) ? $clog2(GROUP) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              pilot_fire,
    input  logic              data_fire,
    output logic [ADDR_W-1:0] pilot_addr,
    output logic [ADDR_W-1:0] data_addr,
    output logic              pilot_room,
    output logic              data_room,
    output logic              complete
);
    localparam logic [ADDR_W-1:0] P_START = ADDR_W'(GUARD);
    localparam logic [ADDR_W-1:0] D_START = ADDR_W'(GUARD + 1);
    localparam logic [ADDR_W-1:0] STRIDE  = ADDR_W'(GROUP + 1);
    localparam logic [SUB_W-1:0]  SUB_END = SUB_W'(GROUP - 1);
    localparam logic [CNT_W-1:0]  P_MAX   = CNT_W'(PILOTS);
    localparam logic [CNT_W-1:0]  D_MAX   = CNT_W'(DATA_N);

    logic [CNT_W-1:0] p_cnt, d_cnt;
    logic [SUB_W-1:0] d_sub;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            p_cnt      <= '0;
            pilot_addr <= P_START;
        end else if (pilot_fire) begin
            p_cnt      <= p_cnt + 1'b1;
            pilot_addr <= pilot_addr + STRIDE;
        end
    end

    // Data skips the pilot slot at each group boundary
    always_ff @(posedge clk) begin
        if (rst || clear) begin
            d_cnt     <= '0;
            d_sub     <= '0;
            data_addr <= D_START;
        end else if (data_fire) begin
            d_cnt <= d_cnt + 1'b1;
            if (d_sub == SUB_END) begin
                d_sub     <= '0;
                data_addr <= data_addr + ADDR_W'(2);
            end else begin
                d_sub     <= d_sub + 1'b1;
                data_addr <= data_addr + ADDR_W'(1);
            end
        end
    end

    assign pilot_room = (p_cnt != P_MAX);
    assign data_room  = (d_cnt != D_MAX);
    assign complete   = !pilot_room && !data_room;

endmodule

// File: rtl/asm_symbol_ram.sv
module asm_symbol_ram #(
    parameter int DEPTH = sc_asm_pkg::FFT_N_DEF,
    parameter int WIDTH = 2 * sc_asm_pkg::IQ_W_DEF,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [WIDTH-1:0]  wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [WIDTH-1:0]  rdata
);
    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        rdata <= mem[raddr];
    end

endmodule

// File: rtl/asm_readout.sv
module asm_readout #(
    parameter int FFT_N  = sc_asm_pkg::FFT_N_DEF,
    parameter int GUARD  = sc_asm_pkg::GUARD_DEF,
    parameter int OCC    = sc_asm_pkg::PILOTS_DEF * (sc_asm_pkg::GROUP_DEF + 1),
    parameter int WIDTH  = 2 * sc_asm_pkg::IQ_W_DEF,
    localparam int ADDR_W = $clog2(FFT_N)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              active,
    output logic              done,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [WIDTH-1:0]  rd_data,
    output logic              out_valid,
    output logic              out_last,
    output logic [WIDTH-1:0]  out_data
);
    localparam logic [ADDR_W-1:0] LAST_BIN = ADDR_W'(FFT_N - 1);

    logic [ADDR_W-1:0] ptr;
    logic              q_valid, q_last, q_null;

    assign done    = active && (ptr == LAST_BIN);
    assign rd_addr = ptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr     <= '0;
            q_valid <= 1'b0;
            q_last  <= 1'b0;
            q_null  <= 1'b0;
        end else begin
            q_valid <= active;
            q_last  <= done;
            q_null  <= sc_asm_pkg::outside_band(int'(ptr), GUARD, GUARD + OCC);
            if (active) begin
                ptr <= done ? '0 : ptr + 1'b1;
            end
        end
    end

    // Guard bins are masked on every pass, never stored
    assign out_valid = q_valid;
    assign out_last  = q_last;
    assign out_data  = q_null ? '0 : rd_data;

endmodule

// File: rtl/subcarrier_assembler.sv
module subcarrier_assembler #(
    parameter int FFT_N  = sc_asm_pkg::FFT_N_DEF,
    parameter int GUARD  = sc_asm_pkg::GUARD_DEF,
    parameter int PILOTS = sc_asm_pkg::PILOTS_DEF,
    parameter int GROUP  = sc_asm_pkg::GROUP_DEF,
    parameter int IQ_W   = sc_asm_pkg::IQ_W_DEF,
    localparam int WORD_W = 2 * IQ_W,
    localparam int ADDR_W = $clog2(FFT_N),
    localparam int OCC    = PILOTS * (GROUP + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pilot_valid,
    output logic              pilot_ready,
    input  logic [WORD_W-1:0] pilot_data,
    input  logic              data_valid,
    output logic              data_ready,
    input  logic [WORD_W-1:0] data_data,
    output logic              out_valid,
    output logic              out_last,
    output logic [WORD_W-1:0] out_data
);
    import sc_asm_pkg::*;

    phase_t            phase;
    logic              pilot_room, data_room, complete, drain_done;
    logic              pilot_fire, data_fire, we;
    logic [ADDR_W-1:0] p_addr, d_addr, waddr, raddr;
    logic [WORD_W-1:0] wdata, rdata;

    // Pilot wins the single write port when both are offered
    assign pilot_ready = (phase == PH_FILL) && pilot_room;
    assign data_ready  = (phase == PH_FILL) && data_room && !(pilot_valid && pilot_room);
    assign pilot_fire  = pilot_valid && pilot_ready;
    assign data_fire   = data_valid && data_ready;

    assign we    = pilot_fire || data_fire;
    assign waddr = pilot_fire ? p_addr : d_addr;
    assign wdata = pilot_fire ? pilot_data : data_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_FILL;
        end else begin
            case (phase)
                PH_FILL:  if (complete)   phase <= PH_DRAIN;
                PH_DRAIN: if (drain_done) phase <= PH_FILL;
                default:                  phase <= PH_FILL;
            endcase
        end
    end

    asm_addr_gen #(
        .FFT_N (FFT_N),
        .GUARD (GUARD),
        .PILOTS(PILOTS),
        .GROUP (GROUP)
    ) u_addr (
        .clk       (clk),
        .rst       (rst),
        .clear     (drain_done),
        .pilot_fire(pilot_fire),
        .data_fire (data_fire),
        .pilot_addr(p_addr),
        .data_addr (d_addr),
        .pilot_room(pilot_room),
        .data_room (data_room),
        .complete  (complete)
    );

    asm_symbol_ram #(
        .DEPTH(FFT_N),
        .WIDTH(WORD_W)
    ) u_ram (
        .clk  (clk),
        .we   (we),
        .waddr(waddr),
        .wdata(wdata),
        .raddr(raddr),
        .rdata(rdata)
    );

    asm_readout #(
        .FFT_N(FFT_N),
        .GUARD(GUARD),
        .OCC  (OCC),
        .WIDTH(WORD_W)
    ) u_rd (
        .clk      (clk),
        .rst      (rst),
        .active   (phase == PH_DRAIN),
        .done     (drain_done),
        .rd_addr  (raddr),
        .rd_data  (rdata),
        .out_valid(out_valid),
        .out_last (out_last),
        .out_data (out_data)
    );

endmodule

// File: rtl/sc_asm_checker.sv
module sc_asm_checker #(
    parameter int FFT_N  = sc_asm_pkg::FFT_N_DEF,
    parameter int GUARD  = sc_asm_pkg::GUARD_DEF,
    parameter int OCC    = sc_asm_pkg::PILOTS_DEF * (sc_asm_pkg::GROUP_DEF + 1),
    parameter int WORD_W = 2 * sc_asm_pkg::IQ_W_DEF,
    localparam int IDX_W = $clog2(FFT_N + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              pilot_valid,
    input logic              pilot_ready,
    input logic              data_ready,
    input logic              out_valid,
    input logic              out_last,
    input logic [WORD_W-1:0] out_data
);
    logic [IDX_W-1:0] idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx <= '0;
        end else if (out_valid) begin
            idx <= out_last ? '0 : idx + 1'b1;
        end
    end

    AST_PILOT_FIRST: assert property (@(posedge clk) disable iff (rst)
        (pilot_valid && pilot_ready) |-> !data_ready);  // R6

    AST_READY_LOW_DRAIN: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_last) |-> (!pilot_ready && !data_ready));  // R9

    AST_LAST_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
        out_last |-> (out_valid && idx == IDX_W'(FFT_N - 1)));  // R8

    AST_STREAM_CONTIG: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_last) |=> out_valid);  // R8

    AST_LAST_THEN_GAP: assert property (@(posedge clk) disable iff (rst)
        out_last |=> !out_valid);  // R8

    AST_GUARD_ZERO: assert property (@(posedge clk) disable iff (rst)
        (out_valid && (int'(idx) < GUARD || int'(idx) >= GUARD + OCC)) |-> (out_data == '0));  // R4

endmodule

bind subcarrier_assembler sc_asm_checker #(
    .FFT_N (FFT_N),
    .GUARD (GUARD),
    .OCC   (OCC),
    .WORD_W(WORD_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .pilot_valid(pilot_valid),
    .pilot_ready(pilot_ready),
    .data_ready (data_ready),
    .out_valid  (out_valid),
    .out_last   (out_last),
    .out_data   (out_data)
);

// File: tb/tb_subcarrier_assembler.sv
`timescale 1ns/1ps
module tb_subcarrier_assembler;
    localparam int NB = 256, GD = 38, NP = 30, ND = 150;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pilot_valid = 1'b0, data_valid = 1'b0;
    logic [21:0] pilot_data = '0, data_data = '0;
    logic        pilot_ready, data_ready, out_valid, out_last;
    logic [21:0] out_data;

    int errors = 0, checks = 0;
    int pk = 0, dj = 0, frames = 0;
    logic [21:0] expv [NB];
    logic [21:0] got  [NB];

    always #2.5 clk = ~clk;

    subcarrier_assembler dut (
        .clk(clk), .rst(rst),
        .pilot_valid(pilot_valid), .pilot_ready(pilot_ready), .pilot_data(pilot_data),
        .data_valid(data_valid), .data_ready(data_ready), .data_data(data_data),
        .out_valid(out_valid), .out_last(out_last), .out_data(out_data)
    );

    function automatic int pilot_bin(int k);
        return GD + 6 * k;
    endfunction

    function automatic int data_bin(int j);
        return GD + 6 * (j / 5) + 1 + (j % 5);
    endfunction

    task automatic check(bit ok, string req, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Output collector: frame contents checked bin by bin
    int idx = 0;
    bit ready_seen = 0;
    initial begin
        forever begin
            @(negedge clk);
            if (out_valid) begin
                if (idx == 0)
                    check(pk == NP && dj == ND, "R7 readout before fill complete", pk + dj, NP + ND);
                if (idx < NB) got[idx] = out_data;
                check(out_last == (idx == NB - 1), "R8 last flag position", out_last, idx == NB - 1);
                if (!out_last && (pilot_ready || data_ready)) ready_seen = 1;
                idx++;
                if (out_last) begin
                    check(idx == NB, "R8 word count", idx, NB);
                    check(!ready_seen, "R9 ready during readout", ready_seen, 0);
                    for (int b = 0; b < NB; b++) begin
                        if (b < GD || b >= GD + NP + ND)
                            check(got[b] == 22'h0, "R4 guard bin", got[b], 0);
                        else if ((b - GD) % 6 == 0)
                            check(got[b] == expv[b], "R2/R10 pilot bin", got[b], expv[b]);
                        else
                            check(got[b] == expv[b], "R3/R10 data bin", got[b], expv[b]);
                    end
                    idx = 0;
                    ready_seen = 0;
                    frames++;
                end
            end
        end
    end

    // mode 0: random gaps, 1: pilots first, 2: data first, 3: both always offered
    task automatic run_symbol(int mode);
        int start_frames = frames;
        pk = 0;
        dj = 0;
        while (pk < NP || dj < ND) begin
            @(negedge clk);
            case (mode)
                0: begin pilot_valid = (pk < NP) && ($urandom % 3 == 0); data_valid = (dj < ND) && ($urandom % 2 == 0); end
                1: begin pilot_valid = 1'b1; data_valid = (pk == NP); end
                2: begin data_valid = 1'b1; pilot_valid = (dj == ND); end
                default: begin pilot_valid = (pk < NP); data_valid = (dj < ND); end
            endcase
            pilot_data = 22'($urandom);
            data_data  = 22'($urandom);
            #1;
            // R5: full stream refuses further words
            if (mode == 1 && pk == NP && dj < ND)
                check(!pilot_ready, "R5 pilot ready after 30", pilot_ready, 0);
            if (mode == 2 && dj == ND && pk < NP)
                check(!data_ready, "R5 data ready after 150", data_ready, 0);
            if (pilot_valid && data_valid && pilot_ready)
                check(!data_ready, "R6 pilot priority", data_ready, 0);
            if (pilot_valid && pilot_ready && pk < NP) begin
                expv[pilot_bin(pk)] = pilot_data;
                pk++;
            end else if (data_valid && data_ready && dj < ND) begin
                expv[data_bin(dj)] = data_data;
                dj++;
            end
        end
        @(negedge clk);
        pilot_valid = 1'b0;
        data_valid  = 1'b0;
        while (frames == start_frames) @(negedge clk);
        check(1'b1, "R11 symbol restart", frames, start_frames + 1);
    endtask

    initial begin
        void'($urandom(32'd4711));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1;
        check(!out_valid, "R1 out_valid after reset", out_valid, 0);
        check(pilot_ready, "R1 pilot_ready after reset", pilot_ready, 1);
        check(data_ready, "R1 data_ready after reset", data_ready, 1);
        run_symbol(0);
        run_symbol(1);
        run_symbol(2);
        run_symbol(3);
        run_symbol(0);
        run_symbol(0);
        check(frames == 6, "R11 frame total", frames, 6);
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired frames=%0d expected=6", frames);
        finish_run();
    end

endmodule